// File: doc/BRIEF.md
# Bistable Trip Decision Logic

This block forms the trip decision for one process variable inside one protection channel. Every accepted sample carries a signed process value, an input-valid flag, two fault flags and an operating-bypass flag. The block compares the value with a trip setpoint. Once tripped, it measures the same value against the setpoint shifted by a signed hysteresis constant. A trip on the comparison is declared only after the condition has held for a configurable number of further samples. A channel fault, a module fault or an invalid input trips the output on the same sample and does not wait for the confirmation count. Operating bypass masks the comparison-based trip. It does not mask the faults.

The sample stream uses a valid/ready pair. `s_ready` is held high, so the block never applies back-pressure. A sample transfers on each rising clock edge where `s_valid` is high. Between transfers, no state changes and the output holds its last value. The active-low output `trip_n` is registered. It takes the decision for a sample at the clock edge that accepts that sample. The setpoint, hysteresis and delay are static configuration pins.

Top module: `bistable_trip`

## Requirements
- R1: Reset drives `trip_n` to 1 and clears the confirmation count and the stored previous trip state. After reset, the first comparison uses the plain setpoint, and a delay of 2 needs three fresh qualifying samples.
- R2: `s_ready` is always 1. With `s_valid` low, `trip_n` and all internal state hold, whatever the other inputs do.
- R3: When the previous sample did not trip on the comparison, the condition is `proc_val >= setpoint`, compared signed. A value equal to the setpoint qualifies.
- R4: When the previous sample tripped on the comparison, the condition is `proc_val >= setpoint + hyst`. The sum is signed two's complement with no overflow. A negative `hyst` keeps the trip set until the value falls below that lowered threshold.
- R5: The confirmation count restarts at 0 on the first sample of a run of samples that meet the condition. It then rises by one per qualifying sample. A comparison trip is declared on the sample where the count is at least `confirm_cnt`, which is the (confirm_cnt+1)-th consecutive qualifying sample. A non-qualifying sample clears the count.
- R6: With `confirm_cnt` = 0, a qualifying sample trips on that same sample, and a non-qualifying sample never trips on the comparison.
- R7: The count saturates at `confirm_cnt` and does not wrap. With the maximum delay of 255, a condition held for 300 samples stays tripped from the 256th sample onward.
- R8: `trip_n` = 0 on any sample with `chan_fault` = 1, `mod_fault` = 1 or `val_ok` = 0, regardless of the count. Faults do not disturb the confirmation count.
- R9: While `op_bypass` = 1, the comparison trip is never asserted and the stored previous trip state is 0. Faults still trip during bypass.
- R10: The hysteresis choice uses the comparison trip state of the immediately preceding accepted sample only. After a release, a value between `setpoint + hyst` and `setpoint` does not re-trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample accepted; constant 1 |
| proc_val | input | VAL_W | Signed process value |
| val_ok | input | 1 | Process value is valid |
| chan_fault | input | 1 | Channel error flag |
| mod_fault | input | 1 | Module error flag |
| op_bypass | input | 1 | Operating bypass active |
| setpoint | input | VAL_W | Signed trip setpoint |
| hyst | input | VAL_W | Signed hysteresis offset applied while tripped |
| confirm_cnt | input | CNT_W | Confirmation delay in samples |
| trip_n | output | 1 | 1 normal, 0 trip |

## Verification
Two functions can act on the same sample: a fault forcing the trip, and the confirmation count progressing or expiring. The bench raises a channel fault in the middle of a qualifying run. It expects a trip on that sample, and it expects the comparison trip to fire on the very next healthy sample, because the count kept running through the fault. A second overlap puts a fault inside operating bypass. The bench judges it by a forced trip that the bypass does not mask, followed by a release threshold that shows the stored previous trip state stayed at 0.

// File: rtl/btrip_pkg.sv
package btrip_pkg;
  typedef enum logic {
    TRIP_ACTIVE = 1'b0,
    TRIP_NORMAL = 1'b1
  } trip_lvl_e;

  typedef struct packed {
    logic chan;
    logic modl;
    logic invalid;
  } fault_t;
endpackage

// File: rtl/btrip_compare.sv
module btrip_compare #(
  parameter int VAL_W = 16
) (
  input  logic signed [VAL_W-1:0] val,
  input  logic signed [VAL_W-1:0] setpoint,
  input  logic signed [VAL_W-1:0] hyst,
  input  logic                    prev_trip,
  output logic                    cond
);
  localparam int EXT_W = VAL_W + 1;

  logic signed [EXT_W-1:0] val_x;
  logic signed [EXT_W-1:0] sp_x;
  logic signed [EXT_W-1:0] hy_x;
  logic signed [EXT_W-1:0] thr_held;
  logic signed [EXT_W-1:0] thr;

  always_comb begin
    val_x    = EXT_W'(val);
    sp_x     = EXT_W'(setpoint);
    hy_x     = EXT_W'(hyst);
    thr_held = sp_x + hy_x;
    // previous comparison trip selects the release threshold
    thr      = prev_trip ? thr_held : sp_x;
    cond     = (val_x >= thr);
  end
endmodule

// File: rtl/btrip_confirm.sv
module btrip_confirm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             cond,
  input  logic [CNT_W-1:0] delay,
  output logic             reached
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             run_q;

  always_comb begin
    if (cond && run_q) begin
      cnt_d = (cnt_q >= delay) ? cnt_q : cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
    reached = cond && (cnt_d >= delay);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_d;
      run_q <= cond;
    end
  end

  // R7: a running count never wraps back to zero
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cond && run_q && cnt_q != '0) |=> (cnt_q != '0));

  // R5: a non-qualifying sample clears the count
  a_r5_clear_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cond) |=> (cnt_q == '0 && !run_q));
endmodule

// File: rtl/btrip_fault_gate.sv
module btrip_fault_gate
  import btrip_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step,
  input  logic   logic_trip,
  input  fault_t faults,
  output logic   trip_n
);
  trip_lvl_e lvl_q;
  trip_lvl_e lvl_d;

  always_comb begin
    if (logic_trip || faults.chan || faults.modl || faults.invalid) begin
      lvl_d = TRIP_ACTIVE;
    end else begin
      lvl_d = TRIP_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= TRIP_NORMAL;
    end else if (step) begin
      lvl_q <= lvl_d;
    end
  end

  assign trip_n = (lvl_q == TRIP_NORMAL);

  // R8: any fault on an accepted sample trips at once
  a_r8_fault_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (faults.chan || faults.modl || faults.invalid)) |=> !trip_n);

  // R2: output holds between accepted samples
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(trip_n));
endmodule

// File: rtl/bistable_trip.sv
module bistable_trip
  import btrip_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic signed [VAL_W-1:0] proc_val,
  input  logic                    val_ok,
  input  logic                    chan_fault,
  input  logic                    mod_fault,
  input  logic                    op_bypass,
  input  logic signed [VAL_W-1:0] setpoint,
  input  logic signed [VAL_W-1:0] hyst,
  input  logic [CNT_W-1:0]        confirm_cnt,
  output logic                    trip_n
);
  logic   step;
  logic   cond;
  logic   reached;
  logic   logic_trip;
  logic   prev_trip_q;
  fault_t faults;

  assign s_ready = 1'b1;
  assign step    = s_valid;

  btrip_compare #(.VAL_W(VAL_W)) u_cmp (
    .val       (proc_val),
    .setpoint  (setpoint),
    .hyst      (hyst),
    .prev_trip (prev_trip_q),
    .cond      (cond)
  );

  btrip_confirm #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .cond    (cond),
    .delay   (confirm_cnt),
    .reached (reached)
  );

  assign logic_trip = reached && !op_bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_trip_q <= 1'b0;
    end else if (step) begin
      prev_trip_q <= logic_trip;
    end
  end

  always_comb begin
    faults.chan    = chan_fault;
    faults.modl    = mod_fault;
    faults.invalid = !val_ok;
  end

  btrip_fault_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .logic_trip (logic_trip),
    .faults     (faults),
    .trip_n     (trip_n)
  );

  // R9: healthy sample in bypass never trips
  a_r9_bypass_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_bypass && val_ok && !chan_fault && !mod_fault) |=> trip_n);

  // R9: bypass leaves no stored comparison trip behind
  a_r9_prev_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op_bypass) |=> !prev_trip_q);
endmodule

// File: tb/bistable_trip_test.sv
module bistable_trip_test;
  localparam int VAL_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [VAL_W-1:0] proc_val = '0;
  logic val_ok = 1'b1;
  logic chan_fault = 1'b0;
  logic mod_fault = 1'b0;
  logic op_bypass = 1'b0;
  logic signed [VAL_W-1:0] setpoint = 16'sd100;
  logic signed [VAL_W-1:0] hyst = -16'sd10;
  logic [CNT_W-1:0] confirm_cnt = 8'd2;
  logic trip_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bistable_trip #(.VAL_W(VAL_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .proc_val(proc_val), .val_ok(val_ok), .chan_fault(chan_fault),
    .mod_fault(mod_fault), .op_bypass(op_bypass), .setpoint(setpoint),
    .hyst(hyst), .confirm_cnt(confirm_cnt), .trip_n(trip_n)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic smp(input int x, input bit ok = 1, input bit ce = 0,
                     input bit me = 0, input bit byp = 0);
    @(negedge clk);
    proc_val = VAL_W'(x);
    val_ok = ok; chan_fault = ce; mod_fault = me; op_bypass = byp;
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    val_ok = 1'b1; chan_fault = 1'b0; mod_fault = 1'b0; op_bypass = 1'b0;
  endtask

  task automatic t_reset;
    confirm_cnt = 0;
    smp(200);
    check("R1 pre-reset tripped", trip_n, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset output", trip_n, 1'b1);
    rst_n = 1'b1;
    confirm_cnt = 2;
    smp(95);
    check("R1 prev trip cleared", trip_n, 1'b1);
    smp(120); check("R1 count cleared s1", trip_n, 1'b1);
    smp(120); check("R1 count cleared s2", trip_n, 1'b1);
    smp(120); check("R1 count cleared s3", trip_n, 1'b0);
    smp(0);
  endtask

  task automatic t_stream;
    confirm_cnt = 0;
    smp(0);
    check("R2 s_ready", s_ready, 1'b1);
    @(negedge clk);
    proc_val = 16'sd500; chan_fault = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 hold without s_valid", trip_n, 1'b1);
    chan_fault = 1'b0;
    smp(0);
    check("R2 state untouched", trip_n, 1'b1);
  endtask

  task automatic t_threshold;
    confirm_cnt = 0;
    smp(99);  check("R3 below setpoint", trip_n, 1'b1);
    smp(100); check("R3 equal setpoint", trip_n, 1'b0);
    smp(50);  check("R3 release", trip_n, 1'b1);
    smp(-300); check("R3 negative value", trip_n, 1'b1);
  endtask

  task automatic t_hyst;
    confirm_cnt = 0; hyst = -16'sd10;
    smp(100); check("R4 trip", trip_n, 1'b0);
    smp(95);  check("R4 held inside band", trip_n, 1'b0);
    smp(90);  check("R4 held at threshold", trip_n, 1'b0);
    smp(89);  check("R4 released below band", trip_n, 1'b1);
    smp(95);  check("R10 previous state used", trip_n, 1'b1);
    smp(100); check("R10 re-trip at setpoint", trip_n, 1'b0);
    smp(0);
  endtask

  task automatic t_delay;
    confirm_cnt = 2;
    smp(0);
    smp(120); check("R5 s1", trip_n, 1'b1);
    smp(120); check("R5 s2", trip_n, 1'b1);
    smp(120); check("R5 s3 trips", trip_n, 1'b0);
    smp(0);   check("R5 release", trip_n, 1'b1);
    smp(120); smp(120);
    smp(0);   check("R5 interrupted", trip_n, 1'b1);
    smp(120); check("R5 restart s1", trip_n, 1'b1);
    smp(120); check("R5 restart s2", trip_n, 1'b1);
    smp(120); check("R5 restart s3", trip_n, 1'b0);
    smp(0);
  endtask

  task automatic t_zero;
    confirm_cnt = 0;
    smp(0);   check("R6 idle normal", trip_n, 1'b1);
    smp(100); check("R6 same-sample trip", trip_n, 1'b0);
    smp(0);   check("R6 no stuck trip", trip_n, 1'b1);
    smp(0);   check("R6 stays normal", trip_n, 1'b1);
  endtask

  task automatic t_sat;
    confirm_cnt = 8'd255;
    smp(0);
    for (int i = 0; i < 300; i++) begin
      smp(120);
      if (i == 254) check("R7 before expiry", trip_n, 1'b1);
      if (i == 255) check("R7 expiry", trip_n, 1'b0);
      if (i == 299) check("R7 no wrap", trip_n, 1'b0);
    end
    smp(0);
  endtask

  task automatic t_fault;
    confirm_cnt = 3;
    smp(0);
    smp(0, 1, 1, 0); check("R8 channel fault", trip_n, 1'b0);
    smp(0);          check("R8 recover", trip_n, 1'b1);
    smp(0, 1, 0, 1); check("R8 module fault", trip_n, 1'b0);
    smp(0, 0, 0, 0); check("R8 invalid input", trip_n, 1'b0);
    smp(0);
    smp(120); smp(120);
    smp(120, 1, 1, 0); check("R8 fault mid count", trip_n, 1'b0);
    smp(120);          check("R8 count kept through fault", trip_n, 1'b0);
    smp(0);            check("R8 final release", trip_n, 1'b1);
  endtask

  task automatic t_bypass;
    confirm_cnt = 0;
    smp(200, 1, 0, 0, 1); check("R9 bypass masks", trip_n, 1'b1);
    smp(200, 1, 1, 0, 1); check("R9 fault in bypass", trip_n, 1'b0);
    smp(95);              check("R9 no stored trip", trip_n, 1'b1);
    smp(200);             check("R9 trip after bypass", trip_n, 1'b0);
    smp(0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 reset state", trip_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_stream();
    t_threshold();
    t_hyst();
    t_delay();
    t_zero();
    t_sat();
    t_fault();
    t_bypass();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule